// File: doc/BRIEF.md
# BCD Calendar Clock

This block keeps wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours, day of week, date, month and a two-digit year that stands for 2000 through 2099. An external sub-second tick feeds a prescaler. After `TICKS_PER_SEC` ticks the time advances by one second. The carries ripple through the minutes, hours, day of week, date, month and year. February gets a 29th day in every year divisible by four.

The hour byte uses a mixed format. When bit 6 is clear it holds a 24-hour BCD value from 00 to 23. When bit 6 is set, bit 5 is the PM flag and bits 4:0 hold 01 to 12 in BCD. Both formats roll over correctly. A control byte at address 7 holds a single active-low run bit in bit 7. While that bit is 1, the clock stands still.

The host loads any field through a write strobe with an address. To read, the host pulses `rd_latch`, which copies all seven time bytes into a snapshot. It then selects bytes from that snapshot with `rd_addr`, so a second boundary in the middle of a burst cannot tear the value it reads.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hour 0x00 (24-hour midnight), day of week 0x01, date 0x01, month 0x01 and year 0x00, and the control byte reads 0x80 (stopped).
- R2: A write with `wr_addr` 0..6 loads seconds, minutes, hour, day of week, date, month or year respectively. Address 7 is the control byte. Only its bit 7 is stored, and its other bits read 0.
- R3: Seconds and minutes count 00..59 in BCD. A field that wraps from 59 to 00 carries one into the next field.
- R4: In 24-hour mode (hour bit 6 = 0) the hour counts 00..23 and wraps from 23 to 00 with a carry into the day.
- R5: In 12-hour mode (bit 6 = 1, bit 5 = PM, bits 4:0 = 01..12 BCD) the order is 12, 01 … 11. The PM flag toggles on the step from 11 to 12. A carry into the day happens only on the step from 11 PM to 12 AM. Bit 6 is never changed by counting.
- R6: The date wraps to 01 after the last day of the month: 31 for months 1, 3, 5, 7, 8, 10 and 12, 30 for months 4, 6, 9 and 11, and 28 for February, or 29 when the year is divisible by 4.
- R7: The month wraps from 12 to 01 and increments the year. The year wraps from 99 to 00.
- R8: The day of week advances at the same step as the date, counting 1..7 and wrapping from 7 to 1.
- R9: While control bit 7 is 1, no field changes and the prescaler holds its count. Counting resumes from the held count when the bit returns to 0.
- R10: A write to any of addresses 0..6 clears the prescaler. The next one-second step comes after exactly `TICKS_PER_SEC` further ticks.
- R11: A pulse on `rd_latch` captures all seven time bytes on that clock edge. `rd_data` for addresses 0..6 then returns the captured bytes, however far the clock advances, until the next pulse. Address 7 returns the live control byte.
- R12: Only clock cycles with `sub_tick` high advance the prescaler. Cycles without a tick change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_tick | input | 1 | Sub-second tick, one clock wide per tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address (0..6 time fields, 7 control) |
| wr_data | input | 8 | Register write data |
| rd_latch | input | 1 | Capture the time fields into the read snapshot |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Selected snapshot byte, or the control byte at address 7 |

## Verification
The bench loads random start times weighted toward the end of a minute, an hour, a day, a month and the century. It then runs one to three seconds and compares every byte with a binary-arithmetic model. A rollover handled wrong shows up as a non-BCD byte such as 0x5A, a 13th month, a 32nd day, a missed or extra 29 February, or a PM flag that toggles on the 12→01 step instead of the 11→12 step. Directed cases cover several further faults:
- stopping the clock mid-second and restarting it, which exposes a prescaler that resets instead of holding its count;
- rewriting seconds one tick before the boundary, which exposes a write that leaves the sub-second count behind;
- running past the boundary after a snapshot, which exposes a read that follows the live registers;
- ticks with random gaps, which expose counting that follows the clock instead of the tick.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef enum logic [2:0] {
        A_SEC   = 3'd0,
        A_MIN   = 3'd1,
        A_HOUR  = 3'd2,
        A_DOW   = 3'd3,
        A_DATE  = 3'd4,
        A_MONTH = 3'd5,
        A_YEAR  = 3'd6,
        A_CTRL  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hour;
        logic [7:0] minute;
        logic [7:0] sec;
    } cal_t;

    typedef struct packed {
        logic [7:0] val;
        logic       carry;
    } hour_step_t;

    localparam logic [7:0] HOUR_12H_BIT = 8'h40;
    localparam logic [7:0] DAYS_PER_WEEK = 8'h07;

    // Add one to a packed two-digit BCD byte (no upper bound).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
        return {v[7:4], v[3:0] + 4'h1};
    endfunction

    // Two-digit BCD year divisible by four.
    function automatic logic year_is_leap(input logic [7:0] y);
        logic [3:0] o;
        o = y[3:0];
        if (!y[4]) return (o == 4'h0) || (o == 4'h4) || (o == 4'h8);
        return (o == 4'h2) || (o == 4'h6);
    endfunction

    function automatic logic [7:0] last_day(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return year_is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // Advance the hour byte in either format, flagging a day carry.
    function automatic hour_step_t hour_adv(input logic [7:0] h);
        hour_step_t r;
        logic [7:0] low;
        low = bcd_inc({3'b000, h[4:0]});
        if (h[6]) begin
            if (h[4:0] == 5'h11) begin
                r.val   = {2'b01, ~h[5], 5'h12};
                r.carry = h[5];
            end else if (h[4:0] == 5'h12) begin
                r.val   = {2'b01, h[5], 5'h01};
                r.carry = 1'b0;
            end else begin
                r.val   = {2'b01, h[5], low[4:0]};
                r.carry = 1'b0;
            end
        end else begin
            r.val   = (h == 8'h23) ? 8'h00 : bcd_inc(h);
            r.carry = (h == 8'h23);
        end
        return r;
    endfunction

endpackage

// File: rtl/rtc_subsec.sv
module rtc_subsec #(
    parameter int TICKS_PER_SEC = 256,
    localparam int CNT_W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sub_tick,
    input  logic             run,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt,
    output logic             sec_step
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

    logic at_last;
    assign at_last  = (cnt == LAST);
    assign sec_step = run && sub_tick && !clear && at_last;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run && sub_tick) begin
            cnt <= at_last ? '0 : cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/rtc_tod_counter.sv
module rtc_tod_counter
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       step,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_q,
    output logic [7:0] min_q,
    output logic [7:0] hour_q,
    output logic       day_carry
);
    localparam int N_SIXTY = 2;

    logic [7:0]       sixty_q [N_SIXTY];
    logic [N_SIXTY:0] wrap;
    hour_step_t       hs;

    assign wrap[0] = step;

    for (genvar g = 0; g < N_SIXTY; g++) begin : g_sixty
        assign wrap[g+1] = wrap[g] && (sixty_q[g] == 8'h59);
        always_ff @(posedge clk) begin
            if (rst) begin
                sixty_q[g] <= 8'h00;
            end else if (wr_en && wr_sel == 3'(g)) begin
                sixty_q[g] <= wr_data;
            end else if (wrap[g]) begin
                sixty_q[g] <= (sixty_q[g] == 8'h59) ? 8'h00 : bcd_inc(sixty_q[g]);
            end
        end
    end

    assign hs = hour_adv(hour_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            hour_q <= 8'h00;
        end else if (wr_en && wr_sel == A_HOUR) begin
            hour_q <= wr_data;
        end else if (wrap[N_SIXTY]) begin
            hour_q <= hs.val;
        end
    end

    assign sec_q     = sixty_q[0];
    assign min_q     = sixty_q[1];
    assign day_carry = wrap[N_SIXTY] && hs.carry;
endmodule

// File: rtl/rtc_date_counter.sv
module rtc_date_counter
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       day_step,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] dow_q,
    output logic [7:0] date_q,
    output logic [7:0] month_q,
    output logic [7:0] year_q
);
    logic month_end, year_end;

    assign month_end = (date_q == last_day(month_q, year_q));
    assign year_end  = month_end && (month_q == 8'h12);

    always_ff @(posedge clk) begin
        if (rst) begin
            dow_q <= 8'h01;
        end else if (wr_en && wr_sel == A_DOW) begin
            dow_q <= wr_data;
        end else if (day_step) begin
            dow_q <= (dow_q == DAYS_PER_WEEK) ? 8'h01 : bcd_inc(dow_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            date_q <= 8'h01;
        end else if (wr_en && wr_sel == A_DATE) begin
            date_q <= wr_data;
        end else if (day_step) begin
            date_q <= month_end ? 8'h01 : bcd_inc(date_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            month_q <= 8'h01;
        end else if (wr_en && wr_sel == A_MONTH) begin
            month_q <= wr_data;
        end else if (day_step && month_end) begin
            month_q <= year_end ? 8'h01 : bcd_inc(month_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            year_q <= 8'h00;
        end else if (wr_en && wr_sel == A_YEAR) begin
            year_q <= wr_data;
        end else if (day_step && year_end) begin
            year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
        end
    end
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       latch,
    input  cal_t       live,
    input  logic [7:0] ctrl,
    input  logic [2:0] rd_addr,
    output cal_t       snap_q,
    output logic [7:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '{year: 8'h00, month: 8'h01, date: 8'h01, dow: 8'h01,
                        hour: 8'h00, minute: 8'h00, sec: 8'h00};
        end else if (latch) begin
            snap_q <= live;
        end
    end

    always_comb begin
        case (rd_addr)
            A_SEC:   rd_data = snap_q.sec;
            A_MIN:   rd_data = snap_q.minute;
            A_HOUR:  rd_data = snap_q.hour;
            A_DOW:   rd_data = snap_q.dow;
            A_DATE:  rd_data = snap_q.date;
            A_MONTH: rd_data = snap_q.month;
            A_YEAR:  rd_data = snap_q.year;
            default: rd_data = ctrl;
        endcase
    end
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
    import rtc_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sub_tick,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_latch,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data
);
    localparam int CNT_W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;

    logic             osc_off_q;
    logic             time_wr;
    logic             sec_step;
    logic             day_step;
    logic [CNT_W-1:0] presc_cnt;
    cal_t             cal_q;
    cal_t             snap_cal;

    assign time_wr = wr_en && (wr_addr != A_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            osc_off_q <= 1'b1;
        end else if (wr_en && wr_addr == A_CTRL) begin
            osc_off_q <= wr_data[7];
        end
    end

    rtc_subsec #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_subsec (
        .clk      (clk),
        .rst      (rst),
        .sub_tick (sub_tick),
        .run      (!osc_off_q),
        .clear    (time_wr),
        .cnt      (presc_cnt),
        .sec_step (sec_step)
    );

    rtc_tod_counter u_tod (
        .clk       (clk),
        .rst       (rst),
        .step      (sec_step),
        .wr_en     (wr_en),
        .wr_sel    (wr_addr),
        .wr_data   (wr_data),
        .sec_q     (cal_q.sec),
        .min_q     (cal_q.minute),
        .hour_q    (cal_q.hour),
        .day_carry (day_step)
    );

    rtc_date_counter u_date (
        .clk      (clk),
        .rst      (rst),
        .day_step (day_step),
        .wr_en    (wr_en),
        .wr_sel   (wr_addr),
        .wr_data  (wr_data),
        .dow_q    (cal_q.dow),
        .date_q   (cal_q.date),
        .month_q  (cal_q.month),
        .year_q   (cal_q.year)
    );

    rtc_snapshot u_snap (
        .clk     (clk),
        .rst     (rst),
        .latch   (rd_latch),
        .live    (cal_q),
        .ctrl    ({osc_off_q, 7'b0}),
        .rd_addr (rd_addr),
        .snap_q  (snap_cal),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker
    import rtc_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 256,
    localparam int CNT_W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             sub_tick,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic             rd_latch,
    input logic             osc_off,
    input logic             sec_step,
    input logic [CNT_W-1:0] presc_cnt,
    input cal_t             cal,
    input cal_t             snap
);
    logic twr;
    assign twr = wr_en && (wr_addr != A_CTRL);

    p_sec_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (sec_step && cal.sec == 8'h59 && !twr) |=> (cal.sec == 8'h00));

    p_mode_kept_r5: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == A_HOUR) |=> $stable(cal.hour[6]));

    p_stopped_r9: assert property (@(posedge clk) disable iff (rst)
        (osc_off && !twr) |=> ($stable(cal) && $stable(presc_cnt)));

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        twr |=> (presc_cnt == '0));

    p_snap_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_latch |=> $stable(snap));

    p_step_needs_tick_r12: assert property (@(posedge clk) disable iff (rst)
        sec_step |-> sub_tick);

    p_no_tick_idle_r12: assert property (@(posedge clk) disable iff (rst)
        (!sub_tick && !wr_en) |=> ($stable(cal) && $stable(presc_cnt)));
endmodule

bind bcd_calendar_clock rtc_cal_checker #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sub_tick  (sub_tick),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .rd_latch  (rd_latch),
    .osc_off   (osc_off_q),
    .sec_step  (sec_step),
    .presc_cnt (presc_cnt),
    .cal       (cal_q),
    .snap      (snap_cal)
);

// File: tb/test_bcd_calendar_clock.sv
module test_bcd_calendar_clock;
    localparam int CLK_PERIOD = 10;
    localparam int TPS = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sub_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_latch = 1'b0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;
    logic [7:0] model [7];

    bcd_calendar_clock #(.TICKS_PER_SEC(TPS)) i_bcd_calendar_clock (
        .clk(clk), .rst(rst), .sub_tick(sub_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_latch(rd_latch),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int b2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int dim(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    // Reference: one second forward, done in binary.
    task automatic model_step();
        int s, mi, h24, h12, d, mo, y;
        bit twelve, pm;
        s = b2i(model[0]) + 1;
        mi = b2i(model[1]);
        twelve = model[2][6];
        if (twelve) begin
            h12 = b2i({3'b000, model[2][4:0]});
            h24 = (h12 % 12) + (model[2][5] ? 12 : 0);
        end else h24 = b2i(model[2]);
        if (s == 60) begin
            s = 0; mi++;
            if (mi == 60) begin
                mi = 0; h24++;
                if (h24 == 24) begin
                    h24 = 0;
                    model[3] = (model[3] == 8'h07) ? 8'h01 : model[3] + 8'h01;
                    d = b2i(model[4]) + 1; mo = b2i(model[5]); y = b2i(model[6]);
                    if (d > dim(mo, y)) begin
                        d = 1; mo++;
                        if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
                    end
                    model[4] = i2b(d); model[5] = i2b(mo); model[6] = i2b(y);
                end
            end
        end
        model[0] = i2b(s); model[1] = i2b(mi);
        if (twelve) begin
            pm = (h24 >= 12);
            h12 = (h24 % 12 == 0) ? 12 : h24 % 12;
            model[2] = {2'b01, pm, 5'(b2i(i2b(h12)) / 10 * 16 + h12 % 10)};
        end else model[2] = i2b(h24);
    endtask

    task automatic check(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_model();
        for (int a = 0; a < 7; a++) wr(3'(a), model[a]);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sub_tick = 1'b1;
        end
        @(negedge clk); sub_tick = 1'b0;
    endtask

    task automatic gapped_ticks(input int n);
        int got;
        got = 0;
        while (got < n) begin
            @(negedge clk);
            sub_tick = ($urandom % 2) == 1;
            if (sub_tick) got++;
        end
        @(negedge clk); sub_tick = 1'b0;
    endtask

    task automatic snap();
        @(negedge clk); rd_latch = 1'b1;
        @(negedge clk); rd_latch = 1'b0;
    endtask

    task automatic read(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); rd_addr = a; #1; v = rd_data;
    endtask

    task automatic check_all(input string req);
        logic [7:0] v;
        snap();
        for (int a = 0; a < 7; a++) begin
            read(3'(a), v);
            check(req, $sformatf("field %0d", a), v, model[a]);
        end
    endtask

    task automatic rand_model();
        int mo, y, h, lim;
        y = ($urandom % 4 == 0) ? 99 : $urandom % 100;
        mo = ($urandom % 3 == 0) ? 12 : 1 + $urandom % 12;
        lim = dim(mo, y);
        case ($urandom % 3)
            0: model[4] = i2b(lim);
            1: model[4] = i2b(lim - 1);
            default: model[4] = i2b(1 + $urandom % lim);
        endcase
        model[5] = i2b(mo); model[6] = i2b(y);
        model[3] = 8'(1 + $urandom % 7);
        model[0] = i2b(56 + $urandom % 4);
        model[1] = ($urandom % 4 != 0) ? 8'h59 : i2b($urandom % 60);
        if ($urandom % 2 == 1) begin
            h = ($urandom % 2 == 1) ? 11 : 1 + $urandom % 12;
            model[2] = {2'b01, 1'($urandom % 2), 5'((h / 10) * 16 + h % 10)};
        end else begin
            h = ($urandom % 2 == 1) ? 23 : $urandom % 24;
            model[2] = i2b(h);
        end
    endtask

    task automatic set_model(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                             input logic [7:0] dw, input logic [7:0] d, input logic [7:0] mo,
                             input logic [7:0] y);
        model[0] = s; model[1] = mi; model[2] = h; model[3] = dw;
        model[4] = d; model[5] = mo; model[6] = y;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        set_model(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        check_all("R1");
        read(3'd7, v); check("R1", "ctrl", v, 8'h80);
        // R9: stopped at reset, ticks do nothing
        ticks(3 * TPS);
        check_all("R9");

        // R2: control holds only bit 7
        wr(3'd7, 8'h7F); read(3'd7, v); check("R2", "ctrl", v, 8'h00);
        wr(3'd7, 8'hFF); read(3'd7, v); check("R2", "ctrl", v, 8'h80);
        wr(3'd7, 8'h00);
        set_model(8'h12, 8'h34, 8'h56 & 8'h1F, 8'h05, 8'h17, 8'h08, 8'h42);
        load_model(); check_all("R2");

        // R5: 11:59:59 AM -> 12 PM, then 12:59:59 PM -> 01 PM, 11:59:59 PM -> 12 AM next day
        set_model(8'h59, 8'h59, 8'h51, 8'h02, 8'h10, 8'h03, 8'h21);
        load_model(); ticks(TPS); model_step(); check_all("R5");
        set_model(8'h59, 8'h59, 8'h72, 8'h02, 8'h10, 8'h03, 8'h21);
        load_model(); ticks(TPS); model_step(); check_all("R5");
        check("R5", "hour 12PM->01PM", model[2], 8'h61);
        set_model(8'h59, 8'h59, 8'h71, 8'h02, 8'h10, 8'h03, 8'h21);
        load_model(); ticks(TPS); model_step(); check_all("R5");

        // R4/R8/R7: 24h midnight at year end, day of week 7 -> 1
        set_model(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        load_model(); ticks(TPS); model_step(); check_all("R7");
        check("R8", "dow wrap", model[3], 8'h01);
        // R6: leap and non-leap February
        set_model(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
        load_model(); ticks(TPS); model_step(); check_all("R6");
        set_model(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
        load_model(); ticks(TPS); model_step(); check_all("R6");
        set_model(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h10);
        load_model(); ticks(TPS); model_step(); check_all("R6");

        // R9: stop mid-second holds prescaler
        set_model(8'h10, 8'h00, 8'h08, 8'h01, 8'h01, 8'h01, 8'h00);
        load_model(); ticks(TPS / 2);
        wr(3'd7, 8'h80); ticks(5 * TPS); check_all("R9");
        wr(3'd7, 8'h00); ticks(TPS / 2 - 1); check_all("R9");
        ticks(1); model_step(); check_all("R9");

        // R10: rewrite one tick before the boundary
        load_model(); ticks(TPS - 1);
        wr(3'd0, model[0]); ticks(TPS - 1); check_all("R10");
        ticks(1); model_step(); check_all("R10");

        // R11: snapshot is frozen while the clock runs
        snap(); ticks(2 * TPS);
        read(3'd0, v); check("R11", "frozen sec", v, model[0]);
        model_step(); model_step(); check_all("R11");

        // R12: gapped ticks
        gapped_ticks(3 * TPS); model_step(); model_step(); model_step(); check_all("R12");

        // R3..R8: random starts near rollovers
        for (int t = 0; t < 150; t++) begin
            int n;
            rand_model(); load_model();
            n = 1 + $urandom % 3;
            if (t % 4 == 0) gapped_ticks(n * TPS); else ticks(n * TPS);
            for (int k = 0; k < n; k++) model_step();
            check_all("R3");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule